// File: doc/BRIEF.md
# Aligned Power-of-Two Vector Allocator

This block hands out contiguous groups of interrupt vectors from a pool of `N_VEC` entries tracked in an internal occupancy bitmap. A client asks for a number of vectors. The block rounds that number up to a power of two. It then looks for the lowest free group of that size whose starting offset is a multiple of the size. If it finds one, it marks the group as taken and answers with the vector number, which is a fixed range base plus the offset. If no group fits, it answers with a failure and leaves the bitmap alone.

A client returns a group by naming its start offset and the count it originally asked for. The same rounding gives the group size, and exactly that group is cleared. If any bit of the returned group was already free, a sticky error flag is raised.

Requests use a valid/ready handshake and are answered by a one-cycle acknowledge pulse. Only one request is in service at a time. An allocation scans its candidate positions one per cycle, so its latency depends on how full the pool is.

Top module: `vec_alloc`

## Requirements
- R1: An allocation of count C reserves a group of 2^k vectors, where 2^k is the smallest power of two not below C (1 gives 1, 3 gives 4, 5 gives 8, 17 gives 32).
- R2: A granted group starts at an offset that is a multiple of its rounded size and lies wholly inside offsets 0 to N_VEC-1.
- R3: Among the aligned groups that fit, the one with the lowest offset is granted.
- R4: When no aligned free group fits, the acknowledge carries `ack_fail`=1 and `ack_vector`=0, and no bitmap bit changes.
- R5: A release (`req_op`=1) rounds the count as in R1 and clears exactly that group, acknowledging one cycle after acceptance with `ack_fail`=0. A release whose start is not a multiple of the rounded size, or whose group runs past N_VEC-1, is acknowledged with `ack_fail`=1 and changes nothing.
- R6: From the cycle after an allocation (`req_op`=0) with a valid count is accepted, `req_ready` stays low until that request's acknowledge.
- R7: A request with count 0 or count above N_VEC is acknowledged with `ack_fail`=1 in the cycle after acceptance.
- R8: A release that covers any vector that is already free sets `rel_err`. The group is still cleared, and `rel_err` stays set until reset.
- R9: A successful allocation reports `ack_vector` = BASE + granted offset.
- R10: After reset the bitmap is empty, `req_ready`=1, `ack`=0 and `rel_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_count | input | CW | Number of vectors requested or returned |
| req_start | input | IW | Start offset of a group being released |
| req_ready | output | 1 | Block can accept a request |
| ack | output | 1 | One-cycle completion pulse |
| ack_fail | output | 1 | Request refused, valid with `ack` |
| ack_vector | output | VW | Granted vector number, valid with `ack` |
| rel_err | output | 1 | Sticky flag: a release covered a free vector |

## Verification
Rejections for bad counts and all releases are due exactly one cycle after the accepting edge. An allocation is due one cycle per candidate position scanned after that edge. The bench therefore drives each request for one cycle and then samples `ack` at every falling edge until it appears, with a bound. Because of this, the variable scan length never shifts which cycle is compared. The bench compares flag and vector at the pulse, and it reads the sticky flag and reset state at falling edges between requests.

// File: rtl/vec_alloc.sv
module vec_alloc #(
  parameter int N_VEC = 24,
  parameter int BASE  = 64,
  parameter int VW    = 11,
  localparam int CW   = $clog2(N_VEC + 1),
  localparam int IW   = $clog2(N_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [CW-1:0] req_count,
  input  logic [IW-1:0] req_start,
  output logic          req_ready,
  output logic          ack,
  output logic          ack_fail,
  output logic [VW-1:0] ack_vector,
  output logic          rel_err
);

  function automatic logic [CW:0] pow2_ceil(input logic [CW-1:0] c);
    logic [CW:0] r;
    r = 1;
    for (int k = 0; k < CW; k++)
      if (r < {1'b0, c}) r = r << 1;
    return r;
  endfunction

  function automatic logic [N_VEC-1:0] span(input int p, input int s);
    logic [N_VEC-1:0] m;
    for (int i = 0; i < N_VEC; i++)
      m[i] = (i >= p) && (i < p + s);
    return m;
  endfunction

  logic [N_VEC-1:0] used;
  logic             busy;
  logic [CW:0]      pos_q, size_q;

  logic [CW:0]      req_size;
  logic             cnt_ok, rel_fit, cand_fits, cand_free;
  logic [N_VEC-1:0] rel_mask, cand_mask;

  assign req_size  = pow2_ceil(req_count);
  assign cnt_ok    = (req_count != '0) && (int'(req_count) <= N_VEC);
  assign rel_fit   = (int'(req_start) + int'(req_size) <= N_VEC) &&
                     ((int'(req_start) & (int'(req_size) - 1)) == 0);
  assign rel_mask  = span(int'(req_start), int'(req_size));
  assign cand_fits = int'(pos_q) + int'(size_q) <= N_VEC;
  assign cand_mask = span(int'(pos_q), int'(size_q));
  assign cand_free = (used & cand_mask) == '0;
  assign req_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used       <= '0;
      busy       <= 1'b0;
      pos_q      <= '0;
      size_q     <= '0;
      ack        <= 1'b0;
      ack_fail   <= 1'b0;
      ack_vector <= '0;
      rel_err    <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          if (!cnt_ok) begin
            ack        <= 1'b1;
            ack_fail   <= 1'b1;
            ack_vector <= '0;
          end else if (!req_op) begin
            busy   <= 1'b1;
            pos_q  <= '0;
            size_q <= req_size;
          end else if (!rel_fit) begin
            ack        <= 1'b1;
            ack_fail   <= 1'b1;
            ack_vector <= '0;
          end else begin
            if ((used & rel_mask) != rel_mask) rel_err <= 1'b1;
            used       <= used & ~rel_mask;
            ack        <= 1'b1;
            ack_fail   <= 1'b0;
            ack_vector <= '0;
          end
        end
      end else if (!cand_fits) begin
        busy       <= 1'b0;
        ack        <= 1'b1;
        ack_fail   <= 1'b1;
        ack_vector <= '0;
      end else if (cand_free) begin
        used       <= used | cand_mask;
        busy       <= 1'b0;
        ack        <= 1'b1;
        ack_fail   <= 1'b0;
        ack_vector <= VW'(BASE) + VW'(pos_q);
      end else begin
        pos_q <= pos_q + size_q;
      end
    end
  end

endmodule

// File: rtl/vec_alloc_chk.sv
module vec_alloc_chk #(
  parameter int N_VEC = 24,
  parameter int BASE  = 64,
  parameter int VW    = 11,
  localparam int CW   = $clog2(N_VEC + 1),
  localparam int IW   = $clog2(N_VEC)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_op,
  input logic [CW-1:0] req_count,
  input logic [IW-1:0] req_start,
  input logic          req_ready,
  input logic          ack,
  input logic          ack_fail,
  input logic [VW-1:0] ack_vector,
  input logic          rel_err
);

  logic accept, good_cnt, last_alloc;
  int   last_size;

  assign accept   = req_valid && req_ready;
  assign good_cnt = (req_count != '0) && (int'(req_count) <= N_VEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_alloc <= 1'b0;
      last_size  <= 1;
    end else if (accept) begin
      last_alloc <= !req_op;
      last_size  <= 1;
      for (int k = 0; k < CW; k++)
        if ((last_size << k) < 0) last_size <= 1;
      for (int s = 1; s <= 2 ** CW; s = s * 2)
        if (s >= int'(req_count) && (s / 2) < int'(req_count)) last_size <= s;
    end
  end

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_op && good_cnt) |=> !req_ready);

  assert_bad_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !good_cnt) |=> (ack && ack_fail));

  assert_release_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op) |=> ack);

  assert_sticky_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);

  assert_aligned_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_fail && last_alloc) |->
      (((int'(ack_vector) - BASE) & (last_size - 1)) == 0 &&
       (int'(ack_vector) - BASE) >= 0 &&
       (int'(ack_vector) - BASE) + last_size <= N_VEC));

  assert_fail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_fail) |-> (ack_vector == '0));

endmodule

bind vec_alloc vec_alloc_chk #(.N_VEC(N_VEC), .BASE(BASE), .VW(VW)) u_chk (.*);

// File: tb/vec_alloc_test.sv
`timescale 1ns/100ps
module vec_alloc_test;
  localparam int N_VEC = 24;
  localparam int BASE  = 64;
  localparam int VW    = 11;
  localparam int CW    = $clog2(N_VEC + 1);
  localparam int IW    = $clog2(N_VEC);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0;
  logic [CW-1:0] req_count = '0;
  logic [IW-1:0] req_start = '0;
  logic req_ready, ack, ack_fail, rel_err;
  logic [VW-1:0] ack_vector;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vec_alloc #(.N_VEC(N_VEC), .BASE(BASE), .VW(VW)) uut (.*);

  // fields: op(1) count(5) start(5) exp_fail(1) exp_vec(11)
  localparam int NT = 15;
  localparam logic [22:0] TV [NT] = '{
    {1'b0, 5'd1,  5'd0, 1'b0, 11'd64},  // R1 R9: offset 0
    {1'b0, 5'd3,  5'd0, 1'b0, 11'd68},  // R1 R2: 3 rounds to 4, offset 4
    {1'b0, 5'd2,  5'd0, 1'b0, 11'd66},  // R3: offset 2 is lowest free pair
    {1'b0, 5'd1,  5'd0, 1'b0, 11'd65},  // R3: hole at 1
    {1'b0, 5'd8,  5'd0, 1'b0, 11'd72},  // R2: offset 8
    {1'b0, 5'd16, 5'd0, 1'b0 | 1'b1, 11'd0}, // R4: 16 cannot fit at 16
    {1'b0, 5'd5,  5'd0, 1'b0, 11'd80},  // R1: 5 rounds to 8, offset 16
    {1'b0, 5'd1,  5'd0, 1'b1, 11'd0},   // R4: pool full
    {1'b1, 5'd3,  5'd4, 1'b0, 11'd0},   // R5: free 4..7
    {1'b0, 5'd4,  5'd0, 1'b0, 11'd68},  // R5 R3: reuses 4..7
    {1'b1, 5'd8,  5'd8, 1'b0, 11'd0},   // R5: free 8..15
    {1'b0, 5'd2,  5'd0, 1'b0, 11'd72},  // R3: offset 8
    {1'b0, 5'd0,  5'd0, 1'b1, 11'd0},   // R7: zero count
    {1'b0, 5'd25, 5'd0, 1'b1, 11'd0},   // R7: count above pool
    {1'b1, 5'd2,  5'd3, 1'b1, 11'd0}    // R5: misaligned release
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input bit op, input int cnt, input int st,
                     output bit got, output bit f, output int v);
    @(negedge clk);
    req_valid = 1; req_op = op; req_count = CW'(cnt); req_start = IW'(st);
    @(negedge clk);
    req_valid = 0;
    got = 0; f = 0; v = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      if (ack) begin got = 1; f = ack_fail; v = int'(ack_vector); end
      else @(negedge clk);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit got, f;
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "ready", req_ready, 1);
    chk("R10", "ack", ack, 0);
    chk("R10", "rel_err", rel_err, 0);

    for (int i = 0; i < NT; i++) begin
      run(TV[i][22], int'(TV[i][21:17]), int'(TV[i][16:12]), got, f, v);
      chk($sformatf("table R3/R4/R9 #%0d", i), "ack", got, 1);
      chk($sformatf("table R3/R4/R9 #%0d", i), "fail", f, int'(TV[i][11]));
      chk($sformatf("table R3/R4/R9 #%0d", i), "vector", v, int'(TV[i][10:0]));
    end
    chk("R8", "rel_err before", rel_err, 0);

    run(1'b1, 2, 10, got, f, v);   // 10..11 already free
    chk("R8", "fail", f, 0);
    chk("R8", "rel_err", rel_err, 1);

    run(1'b0, 2, 0, got, f, v);
    chk("R8", "alloc after", v, 74);
    chk("R8", "rel_err sticky", rel_err, 1);

    run(1'b0, 17, 0, got, f, v);   // rounds to 32
    chk("R1", "17 fail", f, 1);

    run(1'b1, 0, 0, got, f, v);
    chk("R7", "release zero", f, 1);

    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10", "ready after reset", req_ready, 1);
    chk("R10", "rel_err after reset", rel_err, 0);
    run(1'b0, 16, 0, got, f, v);
    chk("R10", "empty pool fail", f, 0);
    chk("R10", "empty pool vector", v, 64);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule